// File: doc/BRIEF.md
# Tracking Error Built-In-Test Monitor

This block supervises the closed loop of a tracking angle converter. Each clock it takes the signed angle error of the loop in LSBs. It also takes two single-bit indications: total loss of the input signals, and overvelocity, meaning the loop can no longer keep up with the input. From these it drives one active-low health flag. The flag is 1 when the loop is healthy and 0 when any fault is present.

The error does not go straight to the comparator. It first passes through a first-order exponential average built from shifts. The time constant is 2^SHIFT clock cycles. Choose SHIFT so that this comes near the half-millisecond settling window the loop needs at the clock rate in use. Because of the average, a brief burst of error does not pull the flag low. A sustained error that exceeds the limit does. Either status indication forces the flag low whatever the error is doing. The flag returns to 1 without any outside action once every cause has gone away.

Both status inputs are asynchronous to the clock, so each passes through a two-flop synchronizer. The flag itself is registered.

Top module: `trk_err_monitor`

## Requirements
- R1: A synchronous active-high reset sets the flag to 1 and clears the filter state to zero. After reset is released with a zero error input, the flag stays 1.
- R2: The flag is 0 while the magnitude of the filtered error is greater than LIMIT (default 100 LSBs). This holds for an error held positive (101, 32767) and negative (-101) long enough for the filter to settle.
- R3: A filtered error of exactly +100 or exactly -100 does not raise a fault. The flag stays 1.
- R4: While loss-of-signal is 1, the flag is 0, even when the error is small (for example 50).
- R5: While overvelocity is 1, the flag is 0, even when the error is small.
- R6: Once the filtered error is within the limit and both status inputs are 0, the flag returns to 1 by itself.
- R7: The filter follows this update rule. With accumulator A, error e and shift S, the next A is A + e - (A >>> S), and the filtered error is A >>> S. With S = 4, starting from zero:
  - one cycle of e = 1000 gives a filtered value of 62, which is no fault;
  - three consecutive cycles of e = 1000 give a filtered value above 100, which is a fault.
- R8: The most negative error word (-32768 at 16 bits) is treated as magnitude 32768. It raises a fault and does not wrap to zero.
- R9: A change on either status input reaches the flag on the third rising clock edge after it is applied, and not on the second.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| err_in | input | ERR_W | Signed loop angle error in LSBs, two's complement |
| los_in | input | 1 | Total loss-of-signal indication, active high, asynchronous |
| ovel_in | input | 1 | Overvelocity indication, active high, asynchronous |
| flag_n | output | 1 | Health flag: 0 = fault, 1 = healthy |

## Verification
The assertions assume that the status inputs hold each value for at least one full clock edge, so the sampled history through the synchronizer reflects what was driven. They also assume the error word is a valid two's-complement value at every rising edge. The bench therefore changes every input only on the falling edge and holds each vector for hundreds of cycles. Because of this, the filter reaches its exact steady value before the flag is judged. Glitch and latency tests are run from a settled zero-error state, so the expected filter values follow from R7 alone.

// File: rtl/trk_bit_pkg.sv
package trk_bit_pkg;

   // Default fault threshold on the filtered error magnitude, in LSBs.
   localparam int unsigned DEF_LIMIT = 100;

   // The causes that can pull the health flag low.
   typedef struct packed {
      logic los;
      logic ovel;
      logic err;
   } fault_src_t;

   function automatic logic any_fault(fault_src_t s);
      return s.los | s.ovel | s.err;
   endfunction

endpackage

// File: rtl/trk_sync_bits.sv
module trk_sync_bits #(
   parameter int unsigned WIDTH  = 2,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] d_in,
   output logic [WIDTH-1:0] d_out
);

   if (STAGES < 2) begin : g_bad_stages
      $error("trk_sync_bits: STAGES must be at least 2");
   end

   for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      logic [STAGES-1:0] chain_q;

      always_ff @(posedge clk) begin
         if (rst) chain_q <= '0;
         else     chain_q <= {chain_q[STAGES-2:0], d_in[b]};
      end

      assign d_out[b] = chain_q[STAGES-1];
   end

endmodule

// File: rtl/trk_lpf.sv
module trk_lpf #(
   parameter int unsigned ERR_W = 16,
   parameter int unsigned SHIFT = 6
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic signed [ERR_W-1:0] err_in,
   output logic signed [ERR_W-1:0] filt
);

   localparam int unsigned ACC_W = ERR_W + SHIFT;

   logic signed [ACC_W-1:0] acc_q;
   logic signed [ACC_W:0]   acc_sum;

   // The upper slice of the accumulator is its arithmetic right shift by SHIFT.
   assign filt = $signed(acc_q[ACC_W-1:SHIFT]);

   always_comb begin
      acc_sum = (ACC_W+1)'(acc_q) + (ACC_W+1)'(err_in) - (ACC_W+1)'(filt);
   end

   // The sum always moves toward err_in << SHIFT, so it never leaves ACC_W bits.
   always_ff @(posedge clk) begin
      if (rst) acc_q <= '0;
      else     acc_q <= acc_sum[ACC_W-1:0];
   end

endmodule

// File: rtl/trk_mag_cmp.sv
module trk_mag_cmp #(
   parameter int unsigned W     = 16,
   parameter int unsigned LIMIT = 100
) (
   input  logic signed [W-1:0] val,
   output logic                over
);

   // One extra bit so that the most negative value keeps its full magnitude.
   logic [W:0] ext;
   logic [W:0] mag;

   assign ext  = {val[W-1], val};
   assign mag  = val[W-1] ? (~ext + 1'b1) : ext;
   assign over = mag > (W+1)'(LIMIT);

endmodule

// File: rtl/trk_err_monitor.sv
module trk_err_monitor
   import trk_bit_pkg::*;
#(
   parameter int unsigned ERR_W       = 16,
   parameter int unsigned SHIFT       = 6,
   parameter int unsigned LIMIT       = DEF_LIMIT,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [ERR_W-1:0] err_in,
   input  logic             los_in,
   input  logic             ovel_in,
   output logic             flag_n
);

   if (ERR_W < 4 || ERR_W > 32) begin : g_bad_width
      $error("trk_err_monitor: ERR_W out of range");
   end
   if (SHIFT < 1 || SHIFT > 16) begin : g_bad_shift
      $error("trk_err_monitor: SHIFT out of range");
   end
   if (LIMIT >= (2 ** (ERR_W - 1))) begin : g_bad_limit
      $error("trk_err_monitor: LIMIT not below full scale");
   end

   logic [1:0]              stat_s;
   logic signed [ERR_W-1:0] filt;
   logic                    err_over;
   fault_src_t              src;
   logic                    flag_q;

   trk_sync_bits #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst   (rst),
      .d_in  ({los_in, ovel_in}),
      .d_out (stat_s)
   );

   trk_lpf #(.ERR_W(ERR_W), .SHIFT(SHIFT)) u_lpf (
      .clk    (clk),
      .rst    (rst),
      .err_in ($signed(err_in)),
      .filt   (filt)
   );

   trk_mag_cmp #(.W(ERR_W), .LIMIT(LIMIT)) u_cmp (
      .val  (filt),
      .over (err_over)
   );

   always_comb begin
      src.los  = stat_s[1];
      src.ovel = stat_s[0];
      src.err  = err_over;
   end

   always_ff @(posedge clk) begin
      if (rst) flag_q <= 1'b1;
      else     flag_q <= ~any_fault(src);
   end

   assign flag_n = flag_q;

endmodule

// File: rtl/trk_bit_chk.sv
module trk_bit_chk #(
   parameter int unsigned ERR_W = 16,
   parameter int unsigned LIMIT = 100
) (
   input logic                    clk,
   input logic                    rst,
   input logic                    los_in,
   input logic                    ovel_in,
   input logic signed [ERR_W-1:0] filt,
   input logic                    flag_n
);

   logic [1:0] since_q;
   logic       rst_q;
   logic [ERR_W:0] fmag;
   logic       big;

   always_ff @(posedge clk) begin
      rst_q <= rst;
      if (rst)                since_q <= '0;
      else if (since_q != 2'd3) since_q <= since_q + 2'd1;
   end

   assign fmag = filt[ERR_W-1] ? (ERR_W+1)'(-(ERR_W+1)'(filt)) : (ERR_W+1)'(filt);
   assign big  = fmag > (ERR_W+1)'(LIMIT);

   // R1: the cycle after a reset edge the flag is healthy
   always_ff @(posedge clk) begin
      if (rst_q) a_r1_healthy_after_reset: assert (flag_n);
   end

   a_r2_over_limit_faults: assert property (@(posedge clk) disable iff (rst)
      big |=> !flag_n);

   a_r4_los_forces_fault: assert property (@(posedge clk) disable iff (rst)
      (since_q == 2'd3 && $past(los_in, 3)) |-> !flag_n);

   a_r5_ovel_forces_fault: assert property (@(posedge clk) disable iff (rst)
      (since_q == 2'd3 && $past(ovel_in, 3)) |-> !flag_n);

   a_r6_clears_when_quiet: assert property (@(posedge clk) disable iff (rst)
      (since_q == 2'd3 && !big && !$past(los_in, 2) && !$past(ovel_in, 2)) |=> flag_n);

endmodule

bind trk_err_monitor trk_bit_chk #(.ERR_W(ERR_W), .LIMIT(LIMIT)) u_chk (
   .clk     (clk),
   .rst     (rst),
   .los_in  (los_in),
   .ovel_in (ovel_in),
   .filt    (filt),
   .flag_n  (flag_n)
);

// File: tb/trk_err_monitor_tb.sv
`timescale 1ns/1ps
module trk_err_monitor_tb;

   localparam int ERR_W = 16;
   localparam int SHIFT = 4;
   localparam int HOLD  = 400;
   localparam int NVEC  = 12;

   // vector: {error[15:0], los, ovel, expected flag}
   localparam logic [18:0] VEC [NVEC] = '{
      {16'sd0,      1'b0, 1'b0, 1'b1},
      {16'sd100,    1'b0, 1'b0, 1'b1},
      {16'sd101,    1'b0, 1'b0, 1'b0},
      {16'sd0,      1'b0, 1'b0, 1'b1},
      {-16'sd100,   1'b0, 1'b0, 1'b1},
      {-16'sd101,   1'b0, 1'b0, 1'b0},
      {16'sd50,     1'b1, 1'b0, 1'b0},
      {16'sd50,     1'b0, 1'b1, 1'b0},
      {16'h8000,    1'b0, 1'b0, 1'b0},
      {16'sd32767,  1'b0, 1'b0, 1'b0},
      {-16'sd50,    1'b0, 1'b0, 1'b1},
      {16'sd0,      1'b0, 1'b0, 1'b1}
   };
   string vtag [NVEC] = '{"R6", "R3", "R2", "R6", "R3", "R2",
                          "R4", "R5", "R8", "R2", "R6", "R6"};

   logic             clk = 1'b0;
   logic             rst = 1'b1;
   logic [ERR_W-1:0] err_in = '0;
   logic             los_in = 1'b0;
   logic             ovel_in = 1'b0;
   logic             flag_n;
   int               n_chk = 0;
   int               n_bad = 0;

   always #2.5 clk = ~clk;

   trk_err_monitor #(.ERR_W(ERR_W), .SHIFT(SHIFT)) u_dut (
      .clk     (clk),
      .rst     (rst),
      .err_in  (err_in),
      .los_in  (los_in),
      .ovel_in (ovel_in),
      .flag_n  (flag_n)
   );

   task automatic step(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(string tag, logic act, logic exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s flag_n actual=%b expected=%b at %0t", tag, act, exp, $time);
      end
   endtask

   initial begin
      #(200000 * 5.0);
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic seen_low;
      logic stayed_high;
      step(3);
      chk("R1", flag_n, 1'b1);
      rst = 1'b0;
      step(5);
      chk("R1", flag_n, 1'b1);

      for (int i = 0; i < NVEC; i++) begin
         err_in  = VEC[i][18:3];
         los_in  = VEC[i][2];
         ovel_in = VEC[i][1];
         step(HOLD);
         chk(vtag[i], flag_n, VEC[i][0]);
      end
      los_in = 1'b0; ovel_in = 1'b0; err_in = '0;
      step(HOLD);

      // R9: loss-of-signal reaches the flag on the third edge
      los_in = 1'b1;
      step(2);
      chk("R9", flag_n, 1'b1);
      step(1);
      chk("R9", flag_n, 1'b0);
      los_in = 1'b0;
      step(2);
      chk("R9", flag_n, 1'b0);
      step(1);
      chk("R6", flag_n, 1'b1);

      // R9: same for overvelocity
      ovel_in = 1'b1;
      step(2);
      chk("R9", flag_n, 1'b1);
      step(1);
      chk("R9", flag_n, 1'b0);
      ovel_in = 1'b0;
      step(HOLD / 4);

      // R7: a single-cycle glitch of 1000 filters to 62 and must not fault
      err_in = 16'sd1000;
      step(1);
      err_in = '0;
      stayed_high = 1'b1;
      for (int k = 0; k < 40; k++) begin
         step(1);
         if (flag_n !== 1'b1) stayed_high = 1'b0;
      end
      chk("R7", stayed_high, 1'b1);

      // R7: three cycles of 1000 push the filtered value past the limit
      err_in = 16'sd1000;
      step(3);
      err_in = '0;
      seen_low = 1'b0;
      for (int k = 0; k < 6; k++) begin
         step(1);
         if (flag_n === 1'b0) seen_low = 1'b1;
      end
      chk("R7", seen_low, 1'b1);
      step(HOLD);
      chk("R6", flag_n, 1'b1);

      // R1: reset from a full-scale fault clears the filter state
      err_in = 16'sd32767;
      step(HOLD);
      chk("R2", flag_n, 1'b0);
      err_in = '0;
      rst = 1'b1;
      step(2);
      chk("R1", flag_n, 1'b1);
      rst = 1'b0;
      stayed_high = 1'b1;
      for (int k = 0; k < 4; k++) begin
         step(1);
         if (flag_n !== 1'b1) stayed_high = 1'b0;
      end
      chk("R1", stayed_high, 1'b1);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule